// File: doc/BRIEF.md
# Sleep Power-Down Controller

This block decides when a small processor core stops and restarts around its low-power state. A sleep instruction strobe from the decoder takes the core out of its running state and holds it halted, but only when a configuration bit allows sleep. While halted, only a prescaled watchdog counter inside the block keeps counting. It is cleared on the cycle the strobe is accepted.

Three events end the halted state. An external active-low reset always wins. A watchdog overflow can end it, but only while the watchdog is enabled. A wakeup request from the pin edge detector ends it last in priority. No exit resumes the interrupted program. Every exit releases the halt and raises a one-cycle request that sends the program counter to the reset vector.

Two status flags record the reason for the last exit. The timeout flag is TO. The power-down flag is PD. Software reads them after the restart.

Top module: `sleep_pd_ctrl`

## Requirements
- R1: While `rst` is high, and in any cycle after an edge that sampled `mclr_n` low, the outputs are `halt`=1, `to_flag`=1, `pd_flag`=1 and `restart`=0. In the first cycle after the release, `halt` is 0 and `restart` is 1.
- R2: Suppose `sleep_exec` and `sleep_en` are both 1 while the core runs. Then `wdt_clr` is 1 in that same cycle. From the next cycle, `halt`=1, `to_flag`=1 and `pd_flag`=0.
- R3: A `sleep_exec` strobe with `sleep_en`=0 has no effect. `wdt_clr` stays 0, `halt` stays 0, and both flags keep their values.
- R4: Let N = 2^(PRE_W+CNT_W). With `wdt_en`=1, `wdt_ovf` pulses for one cycle, N cycles after the clearing edge. A sleep that the watchdog ends therefore holds `halt` high for exactly N+1 cycles, and `wdt_ovf` is high in the last of them.
- R5: A watchdog exit clears `to_flag` and leaves `pd_flag` at 0.
- R6: A `wake_req` while halted ends sleep at the next edge with `to_flag`=1 and `pd_flag`=0. A `wake_req` while running is ignored.
- R7: With `wdt_en`=0, `wdt_ovf` never rises, and sleep lasts until a wakeup or an external reset.
- R8: An external reset while halted keeps `halt` high, sets both flags to 1, and gives no `restart` until `mclr_n` returns high.
- R9: When exit causes coincide, the external reset wins over a watchdog overflow, and an overflow wins over a wakeup. When overflow and wakeup coincide, the exit is a watchdog exit with `to_flag`=0.
- R10: `restart` is high only in the single cycle right after `halt` falls, and is high in every such cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mclr_n | input | 1 | External reset, active low, sampled on the clock |
| sleep_exec | input | 1 | Sleep instruction strobe from the decoder |
| sleep_en | input | 1 | Configuration: sleep allowed |
| wdt_en | input | 1 | Configuration: watchdog enabled |
| wake_req | input | 1 | Wakeup request from the pin edge logic |
| halt | output | 1 | Core halt / clock-gate request |
| wdt_clr | output | 1 | Watchdog clear pulse on sleep entry |
| wdt_ovf | output | 1 | Watchdog overflow pulse |
| to_flag | output | 1 | Timeout status flag |
| pd_flag | output | 1 | Power-down status flag |
| restart | output | 1 | Restart-at-reset-vector request |

## Verification
Each kind of internal fault shows at the ports within a fixed number of cycles:

- **Wrong state register.** A corrupted state value shows within one cycle, either as `halt` in the wrong phase or as a `restart` pulse with no falling `halt` beside it.
- **Wrong flag update.** This appears on `to_flag` or `pd_flag` in the first cycle after the exit or entry that caused it.
- **Watchdog counter not cleared, or wrong prescale.** This changes the length of the halt window away from N+1. The bench measures that length for several counter phases before entry.
- **Wrong priority order.** This flips the flags or suppresses the restart in the cycle after the coinciding causes.

// File: rtl/sleep_pd_pkg.sv
package sleep_pd_pkg;

    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_RUN     = 2'd1,
        ST_SLEEP   = 2'd2,
        ST_RESTART = 2'd3
    } pd_state_e;

    typedef enum logic [1:0] {
        EX_NONE = 2'd0,
        EX_MCLR = 2'd1,
        EX_WDT  = 2'd2,
        EX_PIN  = 2'd3
    } exit_cause_e;

    typedef struct packed {
        logic to;
        logic pd;
    } pd_flags_t;

    localparam pd_flags_t FLAGS_RESET = '{to: 1'b1, pd: 1'b1};
    localparam pd_flags_t FLAGS_SLEEP = '{to: 1'b1, pd: 1'b0};

    // Fixed priority: external reset, then watchdog, then pin wakeup.
    function automatic exit_cause_e pick_exit(input logic mclr_n,
                                              input logic ovf,
                                              input logic wake);
        if (!mclr_n)   return EX_MCLR;
        else if (ovf)  return EX_WDT;
        else if (wake) return EX_PIN;
        else           return EX_NONE;
    endfunction

    function automatic logic state_halts(input pd_state_e st);
        return (st == ST_HOLD) || (st == ST_SLEEP);
    endfunction

endpackage

// File: rtl/spd_watchdog.sv
module spd_watchdog #(
    parameter int PRE_W = 2,
    parameter int CNT_W = 3
) (
    input  logic clk,
    input  logic clr,
    output logic ovf
);
    logic             tick;
    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;

    generate
        if (PRE_W > 0) begin : g_pre
            logic [PRE_W-1:0] pre_q;
            always_ff @(posedge clk) begin
                if (clr) pre_q <= '0;
                else     pre_q <= pre_q + 1'b1;
            end
            assign tick = &pre_q;
        end else begin : g_nopre
            assign tick = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (clr) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            if (tick) cnt_q <= cnt_q + 1'b1;
            ovf_q <= tick && (&cnt_q);
        end
    end

    assign ovf = ovf_q;
endmodule

// File: rtl/spd_exit_arb.sv
module spd_exit_arb
    import sleep_pd_pkg::*;
(
    input  logic        mclr_n,
    input  logic        wdt_ovf,
    input  logic        wdt_en,
    input  logic        wake_req,
    output exit_cause_e cause
);
    always_comb begin
        cause = pick_exit(mclr_n, wdt_ovf && wdt_en, wake_req);
    end
endmodule

// File: rtl/spd_fsm.sv
module spd_fsm
    import sleep_pd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  exit_cause_e cause,
    input  logic        sleep_exec,
    input  logic        sleep_en,
    output pd_state_e   state,
    output pd_flags_t   flags,
    output logic        accept
);
    pd_state_e state_q, state_d;
    pd_flags_t flags_q, flags_d;
    logic      acc_d;

    always_comb begin
        state_d = state_q;
        flags_d = flags_q;
        acc_d   = 1'b0;
        unique case (state_q)
            ST_HOLD:    state_d = ST_RESTART;
            ST_RUN: begin
                if (sleep_exec && sleep_en) begin
                    acc_d   = 1'b1;
                    state_d = ST_SLEEP;
                    flags_d = FLAGS_SLEEP;
                end
            end
            ST_SLEEP: begin
                if (cause == EX_WDT) begin
                    state_d    = ST_RESTART;
                    flags_d.to = 1'b0;
                end else if (cause == EX_PIN) begin
                    state_d = ST_RESTART;
                end
            end
            ST_RESTART: state_d = ST_RUN;
            default:    state_d = ST_HOLD;
        endcase
        if (cause == EX_MCLR) begin
            state_d = ST_HOLD;
            flags_d = FLAGS_RESET;
            acc_d   = 1'b0;
        end
        if (rst) acc_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HOLD;
            flags_q <= FLAGS_RESET;
        end else begin
            state_q <= state_d;
            flags_q <= flags_d;
        end
    end

    assign state  = state_q;
    assign flags  = flags_q;
    assign accept = acc_d;
endmodule

// File: rtl/sleep_pd_ctrl.sv
module sleep_pd_ctrl
    import sleep_pd_pkg::*;
#(
    parameter int PRE_W = 10,
    parameter int CNT_W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic mclr_n,
    input  logic sleep_exec,
    input  logic sleep_en,
    input  logic wdt_en,
    input  logic wake_req,
    output logic halt,
    output logic wdt_clr,
    output logic wdt_ovf,
    output logic to_flag,
    output logic pd_flag,
    output logic restart
);
    exit_cause_e cause;
    pd_state_e   state;
    pd_flags_t   flags;
    logic        accept;
    logic        ovf;
    logic        wd_clear;

    assign wd_clear = rst || !mclr_n || accept || !wdt_en;

    spd_watchdog #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_wdt (
        .clk (clk),
        .clr (wd_clear),
        .ovf (ovf)
    );

    spd_exit_arb u_arb (
        .mclr_n   (mclr_n),
        .wdt_ovf  (ovf),
        .wdt_en   (wdt_en),
        .wake_req (wake_req),
        .cause    (cause)
    );

    spd_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .cause      (cause),
        .sleep_exec (sleep_exec),
        .sleep_en   (sleep_en),
        .state      (state),
        .flags      (flags),
        .accept     (accept)
    );

    assign halt    = state_halts(state);
    assign restart = (state == ST_RESTART);
    assign wdt_clr = accept;
    assign wdt_ovf = ovf;
    assign to_flag = flags.to;
    assign pd_flag = flags.pd;
endmodule

// File: rtl/sleep_pd_ctrl_chk.sv
module sleep_pd_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic mclr_n,
    input logic sleep_exec,
    input logic sleep_en,
    input logic wdt_en,
    input logic wake_req,
    input logic halt,
    input logic wdt_clr,
    input logic wdt_ovf,
    input logic to_flag,
    input logic pd_flag,
    input logic restart
);
    AST_MCLR_FLAGS: assert property (@(posedge clk) disable iff (rst)
        !mclr_n |=> (halt && to_flag && pd_flag && !restart)); // R1

    AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (sleep_exec && sleep_en && !halt && !restart && mclr_n)
        |=> (halt && to_flag && !pd_flag)); // R2

    AST_CLR_WHILE_RUNNING: assert property (@(posedge clk) disable iff (rst)
        wdt_clr |-> (!halt && sleep_exec && sleep_en)); // R2

    AST_DISABLED_SLEEP_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!halt && !restart && !sleep_en && mclr_n) |=> !halt); // R3

    AST_WDT_EXIT_CLEARS_TO: assert property (@(posedge clk) disable iff (rst)
        (halt && !pd_flag && wdt_ovf && mclr_n) |=> (restart && !to_flag && !pd_flag)); // R5

    AST_PIN_EXIT_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (halt && !pd_flag && wake_req && !wdt_ovf && mclr_n)
        |=> (restart && to_flag && !pd_flag)); // R6

    AST_NO_OVF_DISABLED: assert property (@(posedge clk) disable iff (rst)
        !wdt_en |=> !wdt_ovf); // R7

    AST_RESTART_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        restart |-> (!halt && $past(halt))); // R10

    AST_FALL_GIVES_RESTART: assert property (@(posedge clk) disable iff (rst)
        $fell(halt) |-> restart); // R10
endmodule

bind sleep_pd_ctrl sleep_pd_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .mclr_n     (mclr_n),
    .sleep_exec (sleep_exec),
    .sleep_en   (sleep_en),
    .wdt_en     (wdt_en),
    .wake_req   (wake_req),
    .halt       (halt),
    .wdt_clr    (wdt_clr),
    .wdt_ovf    (wdt_ovf),
    .to_flag    (to_flag),
    .pd_flag    (pd_flag),
    .restart    (restart)
);

// File: tb/sleep_pd_ctrl_tb.sv
module sleep_pd_ctrl_tb;
    localparam int PRE_W = 2;
    localparam int CNT_W = 3;
    localparam int NPER  = 1 << (PRE_W + CNT_W);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mclr_n = 1'b1, sleep_exec = 1'b0, sleep_en = 1'b0;
    logic wdt_en = 1'b0, wake_req = 1'b0;
    logic halt, wdt_clr, wdt_ovf, to_flag, pd_flag, restart;

    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    sleep_pd_ctrl #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .mclr_n(mclr_n), .sleep_exec(sleep_exec),
        .sleep_en(sleep_en), .wdt_en(wdt_en), .wake_req(wake_req),
        .halt(halt), .wdt_clr(wdt_clr), .wdt_ovf(wdt_ovf),
        .to_flag(to_flag), .pd_flag(pd_flag), .restart(restart)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // outputs as {halt,restart,to,pd}
    task automatic chk_out(input string req, input logic [3:0] exp);
        chk(req, "halt,restart,to,pd", int'({halt, restart, to_flag, pd_flag}), int'(exp));
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Accept a sleep strobe; returns in the first halted cycle.
    task automatic enter_sleep();
        sleep_exec = 1'b1; sleep_en = 1'b1;
        #1 chk("R2", "wdt_clr on accept", int'(wdt_clr), 1);
        step();
        sleep_exec = 1'b0;
        chk_out("R2", 4'b1010);
    endtask

    // Wake with a pin request and return to running.
    task automatic pin_exit();
        wake_req = 1'b1;
        step();
        wake_req = 1'b0;
        chk_out("R6", 4'b0110);
        step();
        chk_out("R10", 4'b0010);
    endtask

    initial begin
        repeat (3) step();
        chk_out("R1", 4'b1011);
        rst = 1'b0;
        step();
        chk_out("R1", 4'b0111);
        step();
        chk_out("R10", 4'b0011);

        // R3: strobe with sleep disabled is ignored
        sleep_exec = 1'b1; sleep_en = 1'b0;
        #1 chk("R3", "wdt_clr", int'(wdt_clr), 0);
        step();
        sleep_exec = 1'b0;
        chk_out("R3", 4'b0011);

        // R6: wakeup while running ignored
        wake_req = 1'b1;
        step();
        wake_req = 1'b0;
        chk_out("R6", 4'b0011);

        // R6: pin exit after varying sleep lengths, watchdog off
        for (int d = 0; d < 8; d++) begin
            enter_sleep();
            for (int k = 0; k < d; k++) begin
                step();
                chk_out("R6", 4'b1010);
            end
            pin_exit();
        end

        // R7: watchdog disabled keeps sleeping
        enter_sleep();
        for (int k = 0; k < 3 * NPER; k++) begin
            step();
            if (k % 16 == 0 || wdt_ovf || !halt) begin
                chk("R7", "ovf", int'(wdt_ovf), 0);
                chk("R7", "halt", int'(halt), 1);
            end
        end
        pin_exit();

        // R4/R5: watchdog exit for several counter phases before entry
        wdt_en = 1'b1;
        for (int ph = 0; ph < 6; ph++) begin
            int hcnt;
            int ovf_at;
            repeat (ph * 3 + 1) step();
            enter_sleep();
            hcnt = 1; ovf_at = (wdt_ovf) ? 1 : -1;
            while (halt && hcnt < 4 * NPER) begin
                step();
                if (halt) begin
                    hcnt++;
                    if (wdt_ovf) ovf_at = hcnt;
                end
            end
            chk("R4", "halt cycles", hcnt, NPER + 1);
            chk("R4", "ovf position", ovf_at, NPER + 1);
            chk_out("R5", 4'b0100);
            step();
            chk_out("R10", 4'b0000);
        end

        // R8: external reset while asleep
        wdt_en = 1'b0;
        enter_sleep();
        mclr_n = 1'b0;
        step();
        chk_out("R8", 4'b1011);
        step();
        chk_out("R8", 4'b1011);
        mclr_n = 1'b1;
        step();
        chk_out("R8", 4'b0111);
        step();

        // R1: external reset while running
        mclr_n = 1'b0;
        step();
        mclr_n = 1'b1;
        chk_out("R1", 4'b1011);
        step();
        chk_out("R1", 4'b0111);
        step();

        // R9: reset and wakeup together
        enter_sleep();
        mclr_n = 1'b0; wake_req = 1'b1;
        step();
        mclr_n = 1'b1; wake_req = 1'b0;
        chk_out("R9", 4'b1011);
        step();
        chk_out("R9", 4'b0111);
        step();

        // R9: overflow and wakeup together
        wdt_en = 1'b1;
        enter_sleep();
        while (!wdt_ovf && halt) step();
        wake_req = 1'b1;
        step();
        wake_req = 1'b0;
        chk_out("R9", 4'b0100);
        step();

        // R9: reset and overflow together
        enter_sleep();
        while (!wdt_ovf && halt) step();
        chk("R9", "ovf seen", int'(wdt_ovf), 1);
        mclr_n = 1'b0;
        step();
        mclr_n = 1'b1;
        chk_out("R9", 4'b1011);
        step();
        chk_out("R9", 4'b0111);
        step();

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule